// File: doc/BRIEF.md
# Time-Triggered Pulse Generator

This block drives a small set of output lines. Each line either follows a plain GPIO value or carries pulses from its own generator. A shared timebase reaches the block as two inputs: a 64-bit seconds count and a cycle count within the current second. Software writes each channel's target time into staging words on a simple write port. It then arms the channel with a per-channel strobe bit. The armed channel fires one pulse when the timebase reaches that time. The pulse width is set in clock cycles by a per-channel length register.

The arming strobe copies the staged time into the channel. Later writes to the staging words therefore cannot disturb a pending trigger. A ready flag per channel tells software when it may arm again. A separate fire register starts a pulse at once, without a target time. The block runs on the 125 MHz timebase clock, so one timebase cycle is 8 ns.

Top module: `time_pulse_gen`

## Requirements
- R1: After reset, every bit of `rdy_o` is 1, all channels are in GPIO mode, and `out_o` equals `gpio_i`.
- R2: The staging words of channel k are written at byte address 12k+0 (seconds bits 31:0), 12k+4 (seconds bits 63:32) and 12k+8 (cycle in second, low CYC_W bits). A target in a later second fires at the edge where the timebase equals that seconds and cycle pair.
- R3: Writing bit k of the arm register (address 0x44) to 1 while `rdy_o[k]` is 1 arms channel k. `rdy_o[k]` is 0 from that write's edge onwards. The pulse rises at the first later edge where {seconds, cycle} is at least the armed time. No pulse ever rises without an arm or a fire.
- R4: A target time already in the past when the channel is armed fires at the edge right after the arming edge.
- R5: The pulse stays high for exactly the number of cycles held in the length register of channel k (address 0x50+4k, low LEN_W bits). A length of 0 gives a one-cycle pulse.
- R6: Writing bit k of the fire register (address 0x48) starts a pulse on channel k at the edge that takes the write. The write is ignored while that channel's pulse is already high.
- R7: `rdy_o[k]` returns to 1 at the same edge where the pulse of an armed channel falls. `rdy_o[k]` falls only on an accepted arm or on a pulse start.
- R8: An arm request on a channel whose `rdy_o` bit is 0 is ignored.
- R9: Rewriting a channel's staging words after it is armed does not move its pending pulse.
- R10: Bit k of the mode register (address 0x40) selects `out_o[k]`. A value of 0 passes `gpio_i[k]` and a value of 1 passes the pulse output.
- R11: If an armed target is reached while the channel is still pulsing, the triggered pulse starts one edge after the running pulse has fallen.
- R12: Channels fired together run independently, each with its own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, 125 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the register write |
| wr_data | input | 32 | Register write data |
| now_sec | input | 64 | Timebase seconds |
| now_cyc | input | CYC_W | Timebase cycle within the second |
| gpio_i | input | NUM_CH | Values driven when a channel is in GPIO mode |
| rdy_o | output | NUM_CH | Channel may accept a new arm |
| out_o | output | NUM_CH | Channel output lines |

## Verification
An immediate pulse is visible in the same cycle as the edge that takes the fire write. A past target is visible one edge after the arming write. A future target is visible at the edge whose timebase value equals it. The bench drives the timebase so that edge n carries the value n, which means every expected start cycle can be computed directly.

A driver pushes each expected start cycle and width into a queue for its channel before it issues the write. A monitor samples just after each falling clock edge and matches every completed pulse against the front of that channel's queue. Ready flags are sampled on the last high cycle of a pulse and on the cycle after it.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEC_W    = 64;
  localparam int unsigned CH_BYTES = 12;
  localparam int unsigned OFF_MODE = 'h40;
  localparam int unsigned OFF_ARM  = 'h44;
  localparam int unsigned OFF_FIRE = 'h48;
  localparam int unsigned OFF_LEN  = 'h50;
endpackage

// File: rtl/tpg_cmp.sv
module tpg_cmp
  import tpg_pkg::*;
#(
  parameter int unsigned CYC_W = 28
) (
  input  logic [SEC_W-1:0] now_sec,
  input  logic [CYC_W-1:0] now_cyc,
  input  logic [SEC_W-1:0] at_sec,
  input  logic [CYC_W-1:0] at_cyc,
  output logic             reached
);
  logic sec_after;
  logic sec_equal;

  always_comb begin
    sec_after = (now_sec > at_sec);
    sec_equal = (now_sec == at_sec);
    reached   = sec_after || (sec_equal && (now_cyc >= at_cyc));
  end
endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CYC_W  = 28,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_CH-1:0][SEC_W-1:0]     stage_sec,
  output logic [NUM_CH-1:0][CYC_W-1:0]     stage_cyc,
  output logic [NUM_CH-1:0][LEN_W-1:0]     len,
  output logic [NUM_CH-1:0]                mode,
  output logic [NUM_CH-1:0]                arm_req,
  output logic [NUM_CH-1:0]                fire_req
);
  localparam int unsigned HALF_W = SEC_W / 2;

  logic              hit_mode;
  logic              hit_arm;
  logic              hit_fire;
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] mode_d;

  always_comb begin
    hit_mode = wr_en && (wr_addr == ADDR_W'(OFF_MODE));
    hit_arm  = wr_en && (wr_addr == ADDR_W'(OFF_ARM));
    hit_fire = wr_en && (wr_addr == ADDR_W'(OFF_FIRE));
    mode_d   = hit_mode ? wr_data[NUM_CH-1:0] : mode_q;
    arm_req  = hit_arm  ? wr_data[NUM_CH-1:0] : '0;
    fire_req = hit_fire ? wr_data[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (hit_mode) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic             hit_lo, hit_hi, hit_cy, hit_len;
    logic [SEC_W-1:0] sec_q, sec_d;
    logic [CYC_W-1:0] cyc_q, cyc_d;
    logic [LEN_W-1:0] len_q, len_d;

    always_comb begin
      hit_lo  = wr_en && (wr_addr == ADDR_W'(CH_BYTES * k));
      hit_hi  = wr_en && (wr_addr == ADDR_W'(CH_BYTES * k + 4));
      hit_cy  = wr_en && (wr_addr == ADDR_W'(CH_BYTES * k + 8));
      hit_len = wr_en && (wr_addr == ADDR_W'(OFF_LEN + 4 * k));
      sec_d = sec_q;
      if (hit_lo) sec_d[HALF_W-1:0]     = wr_data;
      if (hit_hi) sec_d[SEC_W-1:HALF_W] = wr_data;
      cyc_d = hit_cy  ? wr_data[CYC_W-1:0] : cyc_q;
      len_d = hit_len ? wr_data[LEN_W-1:0] : len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sec_q <= '0;
      end else if (hit_lo || hit_hi) begin
        sec_q <= sec_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyc_q <= '0;
      end else if (hit_cy) begin
        cyc_q <= cyc_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= '0;
      end else if (hit_len) begin
        len_q <= len_d;
      end
    end

    assign stage_sec[k] = sec_q;
    assign stage_cyc[k] = cyc_q;
    assign len[k]       = len_q;
  end
endmodule

// File: rtl/tpg_chan.sv
module tpg_chan
  import tpg_pkg::*;
#(
  parameter int unsigned CYC_W = 28,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             fire_i,
  input  logic [SEC_W-1:0] stage_sec_i,
  input  logic [CYC_W-1:0] stage_cyc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SEC_W-1:0] now_sec_i,
  input  logic [CYC_W-1:0] now_cyc_i,
  output logic             pulse_o,
  output logic             ready_o
);
  logic             armed_q, armed_d;
  logic [SEC_W-1:0] at_sec_q;
  logic [CYC_W-1:0] at_cyc_q;
  logic             pulse_q, pulse_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_eff;
  logic             reached;
  logic             ready;
  logic             take_arm;
  logic             start_trig;
  logic             start;
  logic             pulse_en;

  tpg_cmp #(.CYC_W(CYC_W)) u_cmp (
    .now_sec (now_sec_i),
    .now_cyc (now_cyc_i),
    .at_sec  (at_sec_q),
    .at_cyc  (at_cyc_q),
    .reached (reached)
  );

  always_comb begin
    ready      = !armed_q && !pulse_q;
    take_arm   = arm_i && ready;
    start_trig = !pulse_q && armed_q && reached;
    start      = start_trig || (!pulse_q && fire_i);
    len_eff    = (len_i == '0) ? LEN_W'(1) : len_i;

    armed_d = armed_q;
    if (take_arm)        armed_d = 1'b1;
    else if (start_trig) armed_d = 1'b0;

    pulse_d = pulse_q;
    cnt_d   = cnt_q;
    if (pulse_q) begin
      if (cnt_q == '0) pulse_d = 1'b0;
      else             cnt_d   = cnt_q - LEN_W'(1);
    end else if (start) begin
      pulse_d = 1'b1;
      cnt_d   = len_eff - LEN_W'(1);
    end
    pulse_en = pulse_q || start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (take_arm || start_trig) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_sec_q <= '0;
      at_cyc_q <= '0;
    end else if (take_arm) begin
      at_sec_q <= stage_sec_i;
      at_cyc_q <= stage_cyc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = pulse_q;
  assign ready_o = ready;
endmodule

// File: rtl/time_pulse_gen.sv
module time_pulse_gen
  import tpg_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CYC_W  = 28,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [63:0]       now_sec,
  input  logic [CYC_W-1:0]  now_cyc,
  input  logic [NUM_CH-1:0] gpio_i,
  output logic [NUM_CH-1:0] rdy_o,
  output logic [NUM_CH-1:0] out_o
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_n_s;
  logic [NUM_CH-1:0][SEC_W-1:0]   stage_sec;
  logic [NUM_CH-1:0][CYC_W-1:0]   stage_cyc;
  logic [NUM_CH-1:0][LEN_W-1:0]   len;
  logic [NUM_CH-1:0]              mode;
  logic [NUM_CH-1:0]              arm_req;
  logic [NUM_CH-1:0]              fire_req;
  logic [NUM_CH-1:0]              pulse_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  tpg_regs #(
    .NUM_CH (NUM_CH),
    .CYC_W  (CYC_W),
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .stage_sec (stage_sec),
    .stage_cyc (stage_cyc),
    .len       (len),
    .mode      (mode),
    .arm_req   (arm_req),
    .fire_req  (fire_req)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    tpg_chan #(
      .CYC_W (CYC_W),
      .LEN_W (LEN_W)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .arm_i       (arm_req[k]),
      .fire_i      (fire_req[k]),
      .stage_sec_i (stage_sec[k]),
      .stage_cyc_i (stage_cyc[k]),
      .len_i       (len[k]),
      .now_sec_i   (now_sec),
      .now_cyc_i   (now_cyc),
      .pulse_o     (pulse_w[k]),
      .ready_o     (rdy_o[k])
    );

    assign out_o[k] = mode[k] ? pulse_w[k] : gpio_i[k];
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NUM_CH-1:0] wr_bits,
  input logic [NUM_CH-1:0] pulse,
  input logic [NUM_CH-1:0] rdy
);
  logic arm_wr;
  logic fire_wr;

  assign arm_wr  = wr_en && (wr_addr == ADDR_W'(OFF_ARM));
  assign fire_wr = wr_en && (wr_addr == ADDR_W'(OFF_FIRE));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R3: an accepted arm drops the ready flag at the next edge
    p_rdy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr && wr_bits[k] && rdy[k]) |=> !rdy[k]);

    // R3: a pulse rises only after an arm was pending or a fire was written
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[k]) |-> ($past(!rdy[k]) || $past(fire_wr && wr_bits[k])));

    // R6: a fire write on an idle channel raises the pulse at once
    p_fire_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_wr && wr_bits[k] && !pulse[k]) |=> pulse[k]);

    // R7: ready stays high unless an arm arrives or a pulse begins
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy[k] && !(arm_wr && wr_bits[k])) |=> (rdy[k] || pulse[k]));
  end
endmodule

bind time_pulse_gen tpg_checker #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_tpg_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_bits (wr_data[NUM_CH-1:0]),
  .pulse   (pulse_w),
  .rdy     (rdy_o)
);

// File: tb/time_pulse_gen_bench.sv
`timescale 1ns/1ps
module time_pulse_gen_bench;
  localparam int CLK_NS = 8;
  localparam int NUM_CH = 5;
  localparam int CYC_W  = 28;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 8;
  localparam int TICKS  = 1000;
  localparam int WDOG   = 60000;

  logic              clk = 1'b1;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [63:0]       now_sec;
  logic [CYC_W-1:0]  now_cyc;
  logic [NUM_CH-1:0] gpio_i;
  logic [NUM_CH-1:0] rdy_o;
  logic [NUM_CH-1:0] out_o;

  int cyc_n = 0;
  int total = 0;
  int bad   = 0;
  bit mon_en = 0;
  bit done   = 0;

  int    exp_start [NUM_CH][$];
  int    exp_len   [NUM_CH][$];
  string exp_tag   [NUM_CH][$];

  always #(CLK_NS/2) clk = ~clk;

  time_pulse_gen #(
    .NUM_CH (NUM_CH), .CYC_W (CYC_W), .LEN_W (LEN_W), .ADDR_W (ADDR_W)
  ) u_time_pulse_gen (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .now_sec (now_sec), .now_cyc (now_cyc),
    .gpio_i (gpio_i), .rdy_o (rdy_o), .out_o (out_o)
  );

  always @(posedge clk) cyc_n <= cyc_n + 1;

  // timebase: edge n sees the value n
  always @(negedge clk) begin
    now_sec <= 64'((cyc_n + 1) / TICKS);
    now_cyc <= CYC_W'((cyc_n + 1) % TICKS);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, output int e);
    wr_addr = ADDR_W'(a);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    e     = cyc_n;
    wr_en = 1'b0;
  endtask

  task automatic push(input int ch, input int s, input int l, input string tag);
    exp_start[ch].push_back(s);
    exp_len[ch].push_back(l);
    exp_tag[ch].push_back(tag);
  endtask

  task automatic wait_to(input int n);
    while (cyc_n < n) @(negedge clk);
  endtask

  // monitor: match each finished pulse against the channel's queue
  logic [NUM_CH-1:0] prev = '0;
  int rise_at [NUM_CH];
  always begin
    @(negedge clk);
    #1;
    if (mon_en) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (out_o[ch] && !prev[ch]) begin
          rise_at[ch] = cyc_n;
        end else if (!out_o[ch] && prev[ch]) begin
          if (exp_start[ch].size() == 0) begin
            check(1'b0, "R3", $sformatf("unexpected pulse ch%0d start", ch),
                  rise_at[ch], -1);
          end else begin
            int    es;
            int    el;
            string et;
            es = exp_start[ch].pop_front();
            el = exp_len[ch].pop_front();
            et = exp_tag[ch].pop_front();
            check(rise_at[ch] == es, et, $sformatf("ch%0d start cycle", ch),
                  rise_at[ch], es);
            check(cyc_n - rise_at[ch] == el, "R5", $sformatf("ch%0d width", ch),
                  cyc_n - rise_at[ch], el);
          end
        end
      end
    end
    prev = out_o;
  end

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc_n > WDOG) begin
      check(1'b0, "R3", "watchdog cycles", cyc_n, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e;
    int e2;
    int s;
    int tt;
    int c0;
    int lens [NUM_CH];
    lens = '{1, 8, 0, 3, 20};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; gpio_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(rdy_o == 5'h1F, "R1", "ready after reset", rdy_o, 5'h1F);
    check(out_o == 5'h00, "R1", "outputs after reset", out_o, 0);

    // R10 GPIO pass-through
    gpio_i = 5'b10110; @(negedge clk);
    check(out_o == 5'b10110, "R10", "gpio mode output", out_o, 5'b10110);
    gpio_i = 5'b01001; @(negedge clk);
    check(out_o == 5'b01001, "R10", "gpio mode output", out_o, 5'b01001);

    // lengths and pulse mode
    for (int ch = 0; ch < NUM_CH; ch++) wr('h50 + 4 * ch, lens[ch], e);
    wr('h40, 'h1F, e);
    gpio_i = 5'h1F; @(negedge clk);
    check(out_o == 5'h00, "R10", "pulse mode hides gpio", out_o, 0);
    gpio_i = '0; @(negedge clk);
    mon_en = 1'b1;

    // R12 / R6 / R5: simultaneous immediate pulses, length 0 gives 1
    s = cyc_n + 1;
    for (int ch = 0; ch < NUM_CH; ch++)
      push(ch, s, (lens[ch] == 0) ? 1 : lens[ch], "R12");
    wr('h48, 'h1F, e);
    wait_to(s + 25);

    // R6: second fire while pulsing is ignored
    s = cyc_n + 1;
    push(4, s, 20, "R6");
    wr('h48, 'h10, e);
    repeat (4) @(negedge clk);
    wr('h48, 'h10, e2);
    wait_to(s + 26);
    check(exp_start[4].size() == 0, "R6", "pending ch4 items", exp_start[4].size(), 0);

    // R4 / R3 / R7: past target on ch1
    wr(12, 0, e); wr(16, 0, e); wr(20, 0, e);
    s = cyc_n + 1;
    push(1, s + 1, 8, "R4");
    wr('h44, 'h02, e);
    check(rdy_o[1] == 1'b0, "R3", "ch1 ready after arm", rdy_o[1], 0);
    wait_to(e + 8);
    check(rdy_o[1] == 1'b0, "R7", "ch1 ready on last high cycle", rdy_o[1], 0);
    wait_to(e + 9);
    check(rdy_o[1] == 1'b1, "R7", "ch1 ready after fall", rdy_o[1], 1);

    // R2 / R3: target in the next second on ch3
    tt = ((cyc_n / TICKS) + 1) * TICKS + 7;
    wr(36, tt / TICKS, e); wr(40, 0, e); wr(44, tt % TICKS, e);
    push(3, tt, 3, "R2");
    wr('h44, 'h08, e);
    wait_to(tt - 1);
    check(out_o[3] == 1'b0, "R3", "ch3 quiet before target", out_o[3], 0);
    check(rdy_o[3] == 1'b0, "R3", "ch3 busy while armed", rdy_o[3], 0);
    wait_to(tt + 6);

    // R9 / R8: rewrite staging while armed, re-arm while busy
    tt = cyc_n + 40;
    wr(24, tt / TICKS, e); wr(28, 0, e); wr(32, tt % TICKS, e);
    push(2, tt, 1, "R9");
    wr('h44, 'h04, e);
    wr(28, 1, e); wr(32, 0, e);
    wr('h44, 'h04, e);
    wait_to(tt + 3);
    check(rdy_o[2] == 1'b1, "R8", "ch2 ready after its pulse", rdy_o[2], 1);
    wait_to(tt + 60);
    check(out_o[2] == 1'b0, "R8", "ch2 idle after ignored arm", out_o[2], 0);

    // R11: target reached during an immediate pulse on ch4
    c0 = cyc_n;
    tt = c0 + 10;
    wr(48, tt / TICKS, e); wr(52, 0, e); wr(56, tt % TICKS, e);
    wr('h44, 'h10, e);
    s = cyc_n + 1;
    push(4, s, 20, "R6");
    push(4, s + 21, 20, "R11");
    wr('h48, 'h10, e);
    wait_to(s + 45);
    check(rdy_o[4] == 1'b1, "R7", "ch4 ready at end", rdy_o[4], 1);

    // drain
    for (int ch = 0; ch < NUM_CH; ch++)
      check(exp_start[ch].size() == 0, "R3", $sformatf("ch%0d missing pulses", ch),
            exp_start[ch].size(), 0);
    check(rdy_o == 5'h1F, "R7", "all ready at end", rdy_o, 5'h1F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule